// File: doc/BRIEF.md
# Data Taint Propagation Unit

This unit sits beside a host processor and watches its retired operations. For every host register and for every word of a shadow memory it keeps two one-bit marks: a taint mark for sensitive content, and a "data, not code" mark for content that must never be run as instructions. As operations retire, the marks flow from sources to destinations. Arithmetic and logic results take the union of their operands' marks, loads take the marks of the memory word they read, and stores write the marks of the stored register into the memory word. The only operation that clears taint is a result produced while the program counter lies inside a configured range that holds the trusted encryption routine.

Two rules are enforced. A store that carries tainted data into the public-memory range or the I/O range is blocked. An instruction fetch from a word that carries the data mark is trapped. Any content loaded from the I/O range arrives tainted and data-marked. A trap halts the host for good and raises a one-cycle non-maskable interrupt. Every store into an export range costs the host one stall cycle while the check completes.

Software configures the three address ranges and marks registers or memory words as sensitive or as data through a single configuration port. Shadow words are indexed by the low bits of the word address, so addresses that differ only in their upper bits share one shadow word.

Top module: `taint_guard`

## Requirements
- R1: After reset, `stall`, `halt` and `nmi` are 0. All marks are clear. Each range is empty until it is configured (bound registers reset to lower = all ones, upper = 0).
- R2: A retired arithmetic/logic operation (`rt_op`=0) outside the encryption range writes to `rt_rd` a taint mark equal to the OR of the taint marks of `rt_rs1` and `rt_rs2`. An untainted second operand does not wash the taint out.
- R3: An arithmetic/logic operation whose `rt_pc` lies inside the encryption range writes `rt_rd` with taint cleared. The range bounds are inclusive. Bounds are set with `cfg_kind` 0 (lower) and 1 (upper). A result produced at a `rt_pc` one word past the upper bound stays tainted.
- R4: A store (`rt_op`=2) whose `rt_addr` lies inside the public range (`cfg_kind` 2/3) or the I/O range (`cfg_kind` 4/5), both inclusive, is an export. If `rt_rs2` is tainted, `stall` is 1 in the next cycle, `halt` and `nmi` are 1 in the cycle after that, and the shadow word is not written. An address one word outside either range is not an export.
- R5: A store outside the export ranges always proceeds and copies the marks of `rt_rs2` into shadow word `rt_addr[9:2]`. A load (`rt_op`=1) copies that word's marks into `rt_rd`.
- R6: A load from an address inside the I/O range sets both the taint mark and the data mark of `rt_rd`.
- R7: A fetch (`rt_op`=3) whose shadow word `rt_pc[9:2]` carries the data mark sets `halt` and `nmi` one cycle later. A fetch from an unmarked word has no effect.
- R8: The data mark propagates through arithmetic/logic (OR of operands), loads and stores. The data mark is not cleared inside the encryption range.
- R9: `halt` stays 1 until reset. `nmi` is 1 for exactly one cycle per trap. While `halt` is 1, retired operations are ignored and cause no stall.
- R10: A configuration write with `cfg_kind` 6 sets the marks of register `cfg_value[4:0]`. A write with `cfg_kind` 7 sets the marks of shadow word `cfg_value[7:0]`. In both cases the taint mark is `cfg_value[8]` and the data mark is `cfg_value[9]`. Writing 0 removes a mark.
- R11: An export store of untainted data raises `stall` for exactly one cycle and causes no trap.
- R12: A retired operation presented while `stall` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_kind | input | 3 | 0/1 encryption range lower/upper, 2/3 public range, 4/5 I/O range, 6 mark register, 7 mark shadow word |
| cfg_value | input | 32 | Bound value, or index and marks for kinds 6 and 7 |
| rt_valid | input | 1 | A retired operation is presented |
| rt_op | input | 3 | 0 arithmetic/logic, 1 load, 2 store, 3 fetch, other values none |
| rt_pc | input | 32 | Program counter of the operation |
| rt_rs1 | input | 5 | First source register |
| rt_rs2 | input | 5 | Second source register (store data for stores) |
| rt_rd | input | 5 | Destination register |
| rt_addr | input | 32 | Byte address of a load or store |
| stall | output | 1 | Host stall, one cycle after an export store |
| halt | output | 1 | Sticky host halt after a violation |
| nmi | output | 1 | One-cycle non-maskable interrupt pulse |

## Verification
The marks are visible only through later trap decisions. A corrupted mark shows up as a missing or a spurious trap on the first export store or fetch that depends on it. That can be several operations after the corruption, so the vectors chain propagation steps and end each chain with an exposing store or fetch. A wrong stall or trap sequencer shows at the ports within one or two cycles of the triggering operation, and checks sample `stall` in the first cycle and `halt` in the second.

// File: rtl/tg_pkg.sv
package tg_pkg;
   typedef enum logic [2:0] {
      OP_ALU   = 3'd0,
      OP_LOAD  = 3'd1,
      OP_STORE = 3'd2,
      OP_FETCH = 3'd3
   } op_e;

   typedef enum logic [2:0] {
      CK_ENC_LO  = 3'd0,
      CK_ENC_HI  = 3'd1,
      CK_PUB_LO  = 3'd2,
      CK_PUB_HI  = 3'd3,
      CK_IO_LO   = 3'd4,
      CK_IO_HI   = 3'd5,
      CK_MARK_RG = 3'd6,
      CK_MARK_MW = 3'd7
   } cfg_kind_e;

   typedef struct packed {
      logic taint;
      logic data;
   } flag_t;

   localparam int unsigned N_RANGES = 3;
   localparam int unsigned RG_ENC = 0;
   localparam int unsigned RG_PUB = 1;
   localparam int unsigned RG_IO  = 2;
endpackage

// File: rtl/tg_flag_file.sv
module tg_flag_file
   import tg_pkg::*;
#(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned NRD   = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             cfg_we,
   input  logic [$clog2(DEPTH)-1:0]         cfg_idx,
   input  flag_t                            cfg_flags,
   input  logic                             upd_we,
   input  logic [$clog2(DEPTH)-1:0]         upd_idx,
   input  flag_t                            upd_flags,
   input  logic [NRD-1:0][$clog2(DEPTH)-1:0] rd_idx,
   output flag_t [NRD-1:0]                  rd_flags
);
   localparam int unsigned IW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("tg_flag_file: DEPTH must be a power of two of at least 2");
   end
   if (NRD < 1) begin : g_bad_nrd
      $error("tg_flag_file: NRD must be at least 1");
   end

   logic [DEPTH-1:0] taint_q;
   logic [DEPTH-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         taint_q <= '0;
         data_q  <= '0;
      end else begin
         if (cfg_we) begin
            taint_q[cfg_idx] <= cfg_flags.taint;
            data_q[cfg_idx]  <= cfg_flags.data;
         end
         if (upd_we) begin
            taint_q[upd_idx] <= upd_flags.taint;
            data_q[upd_idx]  <= upd_flags.data;
         end
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      logic [IW-1:0] idx;
      assign idx               = rd_idx[p];
      assign rd_flags[p].taint = taint_q[idx];
      assign rd_flags[p].data  = data_q[idx];
   end
endmodule

// File: rtl/tg_range.sv
module tg_range #(
   parameter int unsigned AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_lo,
   input  logic          set_hi,
   input  logic [AW-1:0] value,
   input  logic [AW-1:0] probe,
   output logic          hit
);
   logic [AW-1:0] lo_q;
   logic [AW-1:0] hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q <= '1;
         hi_q <= '0;
      end else begin
         if (set_lo) lo_q <= value;
         if (set_hi) hi_q <= value;
      end
   end

   assign hit = (probe >= lo_q) && (probe <= hi_q);
endmodule

// File: rtl/tg_trap_ctl.sv
module tg_trap_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic fetch_bad,
   input  logic exp_store,
   input  logic store_bad,
   output logic stall,
   output logic halt,
   output logic nmi
);
   logic stall_q, pend_q, halt_q, nmi_q;
   logic raise;

   assign raise = fetch_bad | pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stall_q <= 1'b0;
         pend_q  <= 1'b0;
         halt_q  <= 1'b0;
         nmi_q   <= 1'b0;
      end else begin
         stall_q <= exp_store;
         pend_q  <= store_bad;
         halt_q  <= halt_q | raise;
         nmi_q   <= ~halt_q & raise;
      end
   end

   assign stall = stall_q;
   assign halt  = halt_q;
   assign nmi   = nmi_q;
endmodule

// File: rtl/taint_guard.sv
module taint_guard
   import tg_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned NREG      = 32,
   parameter int unsigned MEM_WORDS = 256
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_valid,
   input  logic [2:0]               cfg_kind,
   input  logic [ADDR_W-1:0]        cfg_value,
   input  logic                     rt_valid,
   input  logic [2:0]               rt_op,
   input  logic [ADDR_W-1:0]        rt_pc,
   input  logic [$clog2(NREG)-1:0]  rt_rs1,
   input  logic [$clog2(NREG)-1:0]  rt_rs2,
   input  logic [$clog2(NREG)-1:0]  rt_rd,
   input  logic [ADDR_W-1:0]        rt_addr,
   output logic                     stall,
   output logic                     halt,
   output logic                     nmi
);
   localparam int unsigned RIW  = $clog2(NREG);
   localparam int unsigned MIW  = $clog2(MEM_WORDS);
   localparam int unsigned IDXW = (RIW > MIW) ? RIW : MIW;
   localparam int unsigned TBIT = IDXW;
   localparam int unsigned DBIT = IDXW + 1;

   if (ADDR_W < DBIT + 1 || ADDR_W < MIW + 2) begin : g_bad_aw
      $error("taint_guard: ADDR_W too narrow for marks and word index");
   end

   // ---- operation decode ----
   logic accept, is_alu, is_load, is_store, is_fetch;
   assign accept   = rt_valid & ~halt & ~stall;
   assign is_alu   = accept & (rt_op == OP_ALU);
   assign is_load  = accept & (rt_op == OP_LOAD);
   assign is_store = accept & (rt_op == OP_STORE);
   assign is_fetch = accept & (rt_op == OP_FETCH);

   // ---- configured ranges: encryption, public, I/O ----
   logic [N_RANGES-1:0] rg_hit;
   for (genvar g = 0; g < N_RANGES; g++) begin : g_rng
      logic [ADDR_W-1:0] probe;
      assign probe = (g == RG_ENC) ? rt_pc : rt_addr;
      tg_range #(.AW(ADDR_W)) u_rng (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_lo (cfg_valid && cfg_kind == 3'(2 * g)),
         .set_hi (cfg_valid && cfg_kind == 3'(2 * g + 1)),
         .value  (cfg_value),
         .probe  (probe),
         .hit    (rg_hit[g])
      );
   end

   logic enc_hit, io_hit, exp_hit;
   assign enc_hit = rg_hit[RG_ENC];
   assign io_hit  = rg_hit[RG_IO];
   assign exp_hit = rg_hit[RG_PUB] | rg_hit[RG_IO];

   // ---- configuration marks ----
   flag_t cfg_flags;
   assign cfg_flags.taint = cfg_value[TBIT];
   assign cfg_flags.data  = cfg_value[DBIT];

   // ---- register marks ----
   flag_t [1:0] rf;
   flag_t       reg_new;
   flag_t [1:0] mf;

   tg_flag_file #(.DEPTH(NREG), .NRD(2)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_valid && cfg_kind == CK_MARK_RG),
      .cfg_idx   (cfg_value[RIW-1:0]),
      .cfg_flags (cfg_flags),
      .upd_we    (is_alu | is_load),
      .upd_idx   (rt_rd),
      .upd_flags (reg_new),
      .rd_idx    ({rt_rs2, rt_rs1}),
      .rd_flags  (rf)
   );

   always_comb begin
      if (is_alu) begin
         reg_new.taint = (rf[0].taint | rf[1].taint) & ~enc_hit;
         reg_new.data  = rf[0].data | rf[1].data;
      end else begin
         reg_new.taint = mf[0].taint | io_hit;
         reg_new.data  = mf[0].data | io_hit;
      end
   end

   // ---- shadow memory marks: port 0 data address, port 1 fetch address ----
   logic store_bad, exp_store, fetch_bad;
   assign exp_store = is_store & exp_hit;
   assign store_bad = exp_store & rf[1].taint;
   assign fetch_bad = is_fetch & mf[1].data;

   tg_flag_file #(.DEPTH(MEM_WORDS), .NRD(2)) u_shadow (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_valid && cfg_kind == CK_MARK_MW),
      .cfg_idx   (cfg_value[MIW-1:0]),
      .cfg_flags (cfg_flags),
      .upd_we    (is_store & ~store_bad),
      .upd_idx   (rt_addr[MIW+1:2]),
      .upd_flags (rf[1]),
      .rd_idx    ({rt_pc[MIW+1:2], rt_addr[MIW+1:2]}),
      .rd_flags  (mf)
   );

   // ---- stall and trap sequencing ----
   tg_trap_ctl u_trap (
      .clk       (clk),
      .rst_n     (rst_n),
      .fetch_bad (fetch_bad),
      .exp_store (exp_store),
      .store_bad (store_bad),
      .stall     (stall),
      .halt      (halt),
      .nmi       (nmi)
   );
endmodule

// File: rtl/tg_checker.sv
module tg_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       accept,
   input logic [2:0] rt_op,
   input logic       exp_hit,
   input logic       fetch_bad,
   input logic       stall,
   input logic       halt,
   input logic       nmi
);
   AST_NMI_SINGLE:     assert property (@(posedge clk) disable iff (!rst_n) nmi |=> !nmi);          // R9
   AST_HALT_HOLDS:     assert property (@(posedge clk) disable iff (!rst_n) halt |=> halt);         // R9
   AST_NMI_WITH_HALT:  assert property (@(posedge clk) disable iff (!rst_n) nmi |-> halt);          // R9
   AST_STALL_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) stall |=> !stall);      // R12
   AST_EXPORT_STALLS:  assert property (@(posedge clk) disable iff (!rst_n)
                          (accept && rt_op == 3'd2 && exp_hit) |=> stall);                         // R4
   AST_FETCH_TRAPS:    assert property (@(posedge clk) disable iff (!rst_n)
                          fetch_bad |=> (halt && nmi));                                             // R7
   AST_HALTED_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
                          (halt && !stall) |=> !stall);                                             // R9
endmodule

bind taint_guard tg_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .accept    (accept),
   .rt_op     (rt_op),
   .exp_hit   (exp_hit),
   .fetch_bad (fetch_bad),
   .stall     (stall),
   .halt      (halt),
   .nmi       (nmi)
);

// File: tb/sim_taint_guard.sv
`timescale 1ns/100ps
module sim_taint_guard;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_valid = 1'b0;
   logic [2:0]  cfg_kind = '0;
   logic [31:0] cfg_value = '0;
   logic        rt_valid = 1'b0;
   logic [2:0]  rt_op = 3'd7;
   logic [31:0] rt_pc = '0;
   logic [4:0]  rt_rs1 = '0, rt_rs2 = '0, rt_rd = '0;
   logic [31:0] rt_addr = '0;
   logic        stall, halt, nmi;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   taint_guard u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_valid(cfg_valid), .cfg_kind(cfg_kind), .cfg_value(cfg_value),
      .rt_valid(rt_valid), .rt_op(rt_op), .rt_pc(rt_pc),
      .rt_rs1(rt_rs1), .rt_rs2(rt_rs2), .rt_rd(rt_rd), .rt_addr(rt_addr),
      .stall(stall), .halt(halt), .nmi(nmi)
   );

   localparam logic [2:0] ALU = 3'd0, LD = 3'd1, ST = 3'd2, FE = 3'd3;

   typedef struct packed {
      logic        rst;
      logic [2:0]  op;
      logic [31:0] pc;
      logic [4:0]  rs1;
      logic [4:0]  rs2;
      logic [4:0]  rd;
      logic [31:0] addr;
      logic        es;
      logic        eh;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t VECS [NV] = '{
      '{1'b1, ST,  32'h400, 5'd0,  5'd5,  5'd0,  32'h2000, 1'b1, 1'b1, 8'd4},  // R4 R10 tainted export
      '{1'b1, ST,  32'h400, 5'd0,  5'd6,  5'd0,  32'h2004, 1'b1, 1'b0, 8'd11}, // R11 clean export
      '{1'b0, ALU, 32'h400, 5'd5,  5'd6,  5'd7,  32'h0,    1'b0, 1'b0, 8'd2},  // R2 mix
      '{1'b0, ST,  32'h400, 5'd0,  5'd7,  5'd0,  32'h3000, 1'b1, 1'b1, 8'd2},  // R2 sticky taint exposed
      '{1'b1, ALU, 32'h100, 5'd6,  5'd5,  5'd8,  32'h0,    1'b0, 1'b0, 8'd3},  // R3 encrypt at lower bound
      '{1'b0, ST,  32'h400, 5'd0,  5'd8,  5'd0,  32'h2010, 1'b1, 1'b0, 8'd3},
      '{1'b0, ALU, 32'h200, 5'd5,  5'd6,  5'd9,  32'h0,    1'b0, 1'b0, 8'd3},  // R3 just past upper bound
      '{1'b0, ST,  32'h400, 5'd0,  5'd9,  5'd0,  32'h2010, 1'b1, 1'b1, 8'd3},
      '{1'b1, ALU, 32'h1FC, 5'd5,  5'd5,  5'd9,  32'h0,    1'b0, 1'b0, 8'd3},  // R3 upper bound inclusive
      '{1'b0, ST,  32'h400, 5'd0,  5'd9,  5'd0,  32'h2FFC, 1'b1, 1'b0, 8'd3},
      '{1'b1, ST,  32'h400, 5'd0,  5'd5,  5'd0,  32'h80,   1'b0, 1'b0, 8'd5},  // R5 private store
      '{1'b0, LD,  32'h400, 5'd0,  5'd0,  5'd10, 32'h80,   1'b0, 1'b0, 8'd5},
      '{1'b0, ST,  32'h400, 5'd0,  5'd10, 5'd0,  32'h2FFC, 1'b1, 1'b1, 8'd5},
      '{1'b1, LD,  32'h400, 5'd0,  5'd0,  5'd11, 32'h3004, 1'b0, 1'b0, 8'd6},  // R6 I/O import
      '{1'b0, ST,  32'h400, 5'd0,  5'd11, 5'd0,  32'h2000, 1'b1, 1'b1, 8'd6},
      '{1'b1, FE,  32'h40,  5'd0,  5'd0,  5'd0,  32'h0,    1'b0, 1'b1, 8'd7},  // R7 fetch marked word
      '{1'b1, FE,  32'h44,  5'd0,  5'd0,  5'd0,  32'h0,    1'b0, 1'b0, 8'd7},  // R7 clean word
      '{1'b1, LD,  32'h400, 5'd0,  5'd0,  5'd12, 32'h3000, 1'b0, 1'b0, 8'd8},  // R8 chain
      '{1'b0, ALU, 32'h100, 5'd12, 5'd6,  5'd13, 32'h0,    1'b0, 1'b0, 8'd8},
      '{1'b0, ST,  32'h400, 5'd0,  5'd13, 5'd0,  32'h100,  1'b0, 1'b0, 8'd8},
      '{1'b0, FE,  32'h100, 5'd0,  5'd0,  5'd0,  32'h0,    1'b0, 1'b1, 8'd8},
      '{1'b1, ST,  32'h400, 5'd0,  5'd5,  5'd0,  32'h1FFC, 1'b0, 1'b0, 8'd4},  // R4 below public
      '{1'b0, ST,  32'h400, 5'd0,  5'd5,  5'd0,  32'h3100, 1'b0, 1'b0, 8'd4},  // R4 above I/O
      '{1'b0, ST,  32'h400, 5'd0,  5'd5,  5'd0,  32'h30FC, 1'b1, 1'b1, 8'd4}   // R4 I/O upper bound
   };

   task automatic check(input string req, input logic act, input logic exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic cfg(input logic [2:0] k, input logic [31:0] v);
      @(negedge clk);
      cfg_valid = 1'b1; cfg_kind = k; cfg_value = v;
      @(negedge clk);
      cfg_valid = 1'b0;
   endtask

   task automatic reset_cfg();
      @(negedge clk);
      rst_n = 1'b0; rt_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      cfg(3'd0, 32'h100);  cfg(3'd1, 32'h1FC);
      cfg(3'd2, 32'h2000); cfg(3'd3, 32'h2FFF);
      cfg(3'd4, 32'h3000); cfg(3'd5, 32'h30FF);
      cfg(3'd6, 32'h0000_0105);  // reg 5 tainted
      cfg(3'd7, 32'h0000_0210);  // word 0x10 data-marked
   endtask

   // drive one op for one edge; caller at a negedge
   task automatic drive(input logic [2:0] op, input logic [31:0] pc, input logic [4:0] s1,
                        input logic [4:0] s2, input logic [4:0] d, input logic [31:0] a);
      rt_valid = 1'b1; rt_op = op; rt_pc = pc; rt_rs1 = s1; rt_rs2 = s2; rt_rd = d; rt_addr = a;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      reset_cfg();
      @(negedge clk);
      check("R1", stall, 1'b0, "stall after reset");
      check("R1", halt,  1'b0, "halt after reset");
      check("R1", nmi,   1'b0, "nmi after reset");

      // table walk
      for (int i = 0; i < NV; i++) begin
         if (VECS[i].rst) reset_cfg();
         @(negedge clk);
         drive(VECS[i].op, VECS[i].pc, VECS[i].rs1, VECS[i].rs2, VECS[i].rd, VECS[i].addr);
         @(negedge clk);
         rt_valid = 1'b0;
         check($sformatf("R%0d", VECS[i].req), stall, VECS[i].es, $sformatf("vec %0d stall", i));
         @(negedge clk);
         check($sformatf("R%0d", VECS[i].req), halt, VECS[i].eh, $sformatf("vec %0d halt", i));
      end

      // R9 nmi pulse, sticky halt, ignore while halted
      reset_cfg();
      @(negedge clk);
      drive(FE, 32'h40, 5'd0, 5'd0, 5'd0, 32'h0);
      @(negedge clk);
      rt_valid = 1'b0;
      check("R9", nmi, 1'b1, "nmi first cycle");
      @(negedge clk);
      check("R9", nmi, 1'b0, "nmi second cycle");
      check("R9", halt, 1'b1, "halt held");
      drive(ST, 32'h400, 5'd0, 5'd6, 5'd0, 32'h2000);
      @(negedge clk);
      rt_valid = 1'b0;
      check("R9", stall, 1'b0, "no stall while halted");
      check("R9", nmi, 1'b0, "no second nmi");
      repeat (3) @(negedge clk);
      check("R9", halt, 1'b1, "halt sticky");

      // R12 op during stall ignored
      reset_cfg();
      @(negedge clk);
      drive(ST, 32'h400, 5'd0, 5'd6, 5'd0, 32'h2000);
      @(negedge clk);
      check("R12", stall, 1'b1, "stall raised");
      drive(ST, 32'h400, 5'd0, 5'd5, 5'd0, 32'h2000);
      @(negedge clk);
      rt_valid = 1'b0;
      check("R12", stall, 1'b0, "stall one cycle");
      @(negedge clk);
      check("R12", halt, 1'b0, "stalled tainted store ignored");
      check("R12", stall, 1'b0, "no stall from ignored store");

      // R10 unmark and mark via configuration
      reset_cfg();
      cfg(3'd6, 32'h0000_0005);   // clear reg 5
      cfg(3'd6, 32'h0000_0114);   // taint reg 20
      @(negedge clk);
      drive(ST, 32'h400, 5'd0, 5'd5, 5'd0, 32'h2000);
      @(negedge clk);
      rt_valid = 1'b0;
      @(negedge clk);
      check("R10", halt, 1'b0, "unmarked reg exports");
      drive(ST, 32'h400, 5'd0, 5'd20, 5'd0, 32'h2000);
      @(negedge clk);
      rt_valid = 1'b0;
      @(negedge clk);
      check("R10", halt, 1'b1, "marked reg trapped");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule